// File: doc/BRIEF.md
# Multicycle Add/Subtract Processor

This block is a tiny processor for a subset of a well-known 32-bit RISC instruction encoding. It runs only three instructions: add-immediate-unsigned, add-unsigned and subtract-unsigned. All of them work on 8-bit data and wrap silently on overflow. Every instruction passes through five fixed controller states: fetch, field split, operand read, execute and write-back. The program counter steps by one word on each fetch. When the counter reaches a configured limit, the controller enters a terminal state. It stays there and shows one chosen register on its output.

Programs go into a small instruction store through a preload port while reset is held. Reset clears the program counter, the controller and all 32 data registers. It leaves the instruction store untouched, so the same program can be run again. Any encoding outside the three supported instructions is marked invalid during execute, and nothing is written back for it.

Top module: `addsub_fsm_core`

## Requirements
- R1: While reset is high, `halted` and `out_val` are 0. Reset is synchronous and active high.
- R2: Reset clears all 32 data registers to 0, so a program that reads a register it never wrote sees 0, even after an earlier run.
- R3: Each instruction takes exactly five clock edges. With reset released, `halted` first reads high after clock edge 5*MAX_PC+1.
- R4: Opcode field [31:26]=0x09 is add-immediate. The destination is field [20:16], the source is field [25:21], and the operand is only immediate bits [7:0]. Immediate bits [15:8] have no effect.
- R5: Opcode 0x00 with function field [5:0]=0x21 and bits [10:6]=0 writes rs+rt, modulo 256, to rd. Here rs is field [25:21], rt is field [20:16] and rd is field [15:11].
- R6: Opcode 0x00 with function 0x23 and bits [10:6]=0 writes rs-rt, modulo 256, to rd.
- R7: Any other word is invalid and changes no register. This includes any other opcode, any other function code, and a nonzero [10:6] field.
- R8: A write aimed at register 0 is dropped, and register 0 always reads 0.
- R9: Exactly MAX_PC instructions run. Words at index MAX_PC and above never take effect. Once `halted` is high, it stays high until reset.
- R10: While `halted` is high, `out_val` shows register OUT_REG. At all other times it is 0.
- R11: A high `ld_en` writes `ld_data` into the instruction store at `ld_addr` on the clock edge. This is allowed only while reset is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Instruction store write enable |
| ld_addr | input | $clog2(IMEM_DEPTH) | Instruction store write index |
| ld_data | input | 32 | Instruction word to store |
| halted | output | 1 | High in the terminal state (registered) |
| out_val | output | DATA_W | Register OUT_REG while halted, else 0 |

## Verification
The assertions assume that the preload port is used only while reset is held. Loading during a run would change instructions under the controller. They also assume MAX_PC does not exceed the store depth. The bench writes each program only inside its reset window, and it keeps the default limit of seven against an eight-word store. Random programs draw registers from a small range so that the output register is often touched. They also mix in invalid opcodes, wrong function codes and nonzero shift fields.

// File: rtl/addsub_fsm_pkg.sv
package addsub_fsm_pkg;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_READ   = 3'd2,
    ST_EXEC   = 3'd3,
    ST_WRITE  = 3'd4,
    ST_HALT   = 3'd5
  } fsm_state_t;

  typedef enum logic [1:0] {
    K_ADDIU,
    K_ADDU,
    K_SUBU,
    K_BAD
  } op_kind_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

endpackage

// File: rtl/addsub_imem.sv
module addsub_imem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/addsub_regfile.sv
module addsub_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] ra_addr,
  output logic [DW-1:0]  ra_data,
  input  logic [RAW-1:0] rb_addr,
  output logic [DW-1:0]  rb_data,
  input  logic [RAW-1:0] rc_addr,
  output logic [DW-1:0]  rc_data
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign rc_data = regs[rc_addr];

  // R8
  zero_reg_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != '0));

  // R8
  zero_reg_value_chk: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

endmodule

// File: rtl/addsub_alu.sv
module addsub_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);

  // modulo 2^DW, carry discarded
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end

endmodule

// File: rtl/addsub_fsm_core.sv
module addsub_fsm_core
  import addsub_fsm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 32,
  parameter int IMEM_DEPTH = 8,
  parameter int MAX_PC     = 7,
  parameter int OUT_REG    = 5,
  localparam int AW        = $clog2(IMEM_DEPTH),
  localparam int RAW       = $clog2(NUM_REGS),
  localparam int PC_W      = $clog2(IMEM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [31:0]       ld_data,
  output logic              halted,
  output logic [DATA_W-1:0] out_val
);

  localparam logic [PC_W-1:0] PC_LIMIT = PC_W'(MAX_PC);
  localparam logic [RAW-1:0]  OUT_SEL  = RAW'(OUT_REG);

  fsm_state_t        state;
  logic [PC_W-1:0]   pc;
  logic [31:0]       iword;
  op_kind_t          kind_q;
  logic [RAW-1:0]    rs_q, rt_q, dst_q;
  logic [DATA_W-1:0] imm_q, opa_q, opb_q, res_q;
  logic              valid_q;
  logic              rf_we;
  logic [DATA_W-1:0] ra_data, rb_data, rc_data, alu_y;
  logic              halted_q;
  logic [DATA_W-1:0] out_q;

  addsub_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(32)) u_imem (
    .clk    (clk),
    .wr_en  (ld_en),
    .wr_addr(ld_addr),
    .wr_data(ld_data),
    .rd_en  (state == ST_FETCH),
    .rd_addr(pc[AW-1:0]),
    .rd_data(iword)
  );

  addsub_regfile #(.DW(DATA_W), .NREG(NUM_REGS)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (dst_q),
    .wdata  (res_q),
    .ra_addr(rs_q),
    .ra_data(ra_data),
    .rb_addr(rt_q),
    .rb_data(rb_data),
    .rc_addr(OUT_SEL),
    .rc_data(rc_data)
  );

  addsub_alu #(.DW(DATA_W)) u_alu (
    .a  (opa_q),
    .b  (opb_q),
    .sub(kind_q == K_SUBU),
    .y  (alu_y)
  );

  // field split of the fetched word
  logic [5:0] f_op, f_fn;
  logic [4:0] f_sh;
  op_kind_t   f_kind;
  assign f_op = iword[31:26];
  assign f_fn = iword[5:0];
  assign f_sh = iword[10:6];

  always_comb begin
    if (f_op == OP_ADDIU)
      f_kind = K_ADDIU;
    else if (f_op == OP_RTYPE && f_sh == '0 && f_fn == FN_ADDU)
      f_kind = K_ADDU;
    else if (f_op == OP_RTYPE && f_sh == '0 && f_fn == FN_SUBU)
      f_kind = K_SUBU;
    else
      f_kind = K_BAD;
  end

  assign rf_we = (state == ST_WRITE) && valid_q && (dst_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      pc       <= '0;
      kind_q   <= K_BAD;
      rs_q     <= '0;
      rt_q     <= '0;
      dst_q    <= '0;
      imm_q    <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      res_q    <= '0;
      valid_q  <= 1'b0;
      halted_q <= 1'b0;
      out_q    <= '0;
    end else begin
      halted_q <= (state == ST_HALT);
      out_q    <= (state == ST_HALT) ? rc_data : '0;
      unique case (state)
        ST_FETCH: begin
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          kind_q <= f_kind;
          rs_q   <= RAW'(iword[25:21]);
          rt_q   <= RAW'(iword[20:16]);
          dst_q  <= (f_op == OP_ADDIU) ? RAW'(iword[20:16]) : RAW'(iword[15:11]);
          imm_q  <= DATA_W'(iword[7:0]);
          state  <= ST_READ;
        end
        ST_READ: begin
          opa_q <= ra_data;
          opb_q <= (kind_q == K_ADDIU) ? imm_q : rb_data;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q   <= alu_y;
          valid_q <= (kind_q != K_BAD);
          state   <= ST_WRITE;
        end
        ST_WRITE: begin
          state <= (pc < PC_LIMIT) ? ST_FETCH : ST_HALT;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign halted  = halted_q;
  assign out_val = out_q;

  // R3
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // R3
  exec_to_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC) |=> (state == ST_WRITE));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R7
  invalid_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && kind_q == K_BAD) |=> !rf_we);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  pc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pc <= PC_LIMIT);

  // R10
  out_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !halted |-> (out_val == '0));

  // R11
  load_in_reset_chk: assert property (@(posedge clk)
    ld_en |-> rst);

endmodule

// File: tb/test_addsub_fsm_core.sv
module test_addsub_fsm_core;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int AW         = 3;
  localparam int MAXPC      = 7;
  localparam int OREG       = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic          halted;
  logic [7:0]    out_val;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] prog [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_fsm_core #(
    .DATA_W(8), .NUM_REGS(32), .IMEM_DEPTH(DEPTH), .MAX_PC(MAXPC), .OUT_REG(OREG)
  ) i_addsub_fsm_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .out_val(out_val)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [4:0] sh, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), sh, fn};
  endfunction

  // reference model built from the requirement text
  function automatic logic [7:0] model_out();
    logic [7:0] r [32];
    for (int i = 0; i < 32; i++) r[i] = 8'h00;
    for (int i = 0; i < MAXPC; i++) begin
      logic [31:0] w;
      logic [7:0]  v;
      int          d;
      bit          ok;
      w  = prog[i];
      ok = 1'b1;
      d  = 0;
      v  = 8'h00;
      if (w[31:26] == 6'h09) begin
        d = int'(w[20:16]);
        v = r[w[25:21]] + w[7:0];
      end else if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h21) begin
        d = int'(w[15:11]);
        v = r[w[25:21]] + r[w[20:16]];
      end else if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h23) begin
        d = int'(w[15:11]);
        v = r[w[25:21]] - r[w[20:16]];
      end else begin
        ok = 1'b0;
      end
      if (ok && d != 0) r[d] = v;
    end
    return r[OREG];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_prog(input string tag);
    int edges;
    logic [7:0] exp;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      ld_en   = 1'b1;
      ld_addr = AW'(i);
      ld_data = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 out_val in reset", {24'd0, out_val}, 32'd0);
    rst   = 1'b0;
    edges = 0;
    while (!halted && edges < 100) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    // R3 five edges per instruction plus one output register stage
    check("R3 edges to halt", edges, 5 * MAXPC + 1);
    exp = model_out();
    check(tag, {24'd0, out_val}, {24'd0, exp});
    repeat (4) @(negedge clk);
    // R9 terminal state holds
    check("R9 halted sticky", {31'd0, halted}, 32'd1);
    check("R10 out_val steady", {24'd0, out_val}, {24'd0, exp});
  endtask

  task automatic fill_nops();
    for (int i = 0; i < DEPTH; i++) prog[i] = enc_r(0, 0, 0, 5'd0, 6'h21);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);

    // R5 R6 R4: small expression program, (45 + -20) - (-60 + 30) = 55
    prog[0] = enc_i(6'h09, 0, 1, 16'd45);
    prog[1] = enc_i(6'h09, 0, 2, 16'hFFEC);
    prog[2] = enc_i(6'h09, 0, 3, 16'hFFC4);
    prog[3] = enc_i(6'h09, 0, 4, 16'd30);
    prog[4] = enc_r(1, 2, 5, 5'd0, 6'h21);
    prog[5] = enc_r(3, 4, 6, 5'd0, 6'h21);
    prog[6] = enc_r(5, 6, 5, 5'd0, 6'h23);
    prog[7] = enc_i(6'h09, 0, 5, 16'd1);   // R9 index MAX_PC never runs
    run_prog("R6 expression result");
    check("R9 result is 55", {24'd0, out_val}, 32'd55);

    // R4 high byte of immediate ignored
    fill_nops();
    prog[0] = enc_i(6'h09, 0, 5, 16'hAB07);
    run_prog("R4 high immediate byte");
    check("R4 value 7", {24'd0, out_val}, 32'd7);

    // R5 wrap on add, R6 wrap on subtract
    fill_nops();
    prog[0] = enc_i(6'h09, 0, 1, 16'h00F0);
    prog[1] = enc_i(6'h09, 0, 2, 16'h0020);
    prog[2] = enc_r(1, 2, 5, 5'd0, 6'h21);
    run_prog("R5 add wraps");
    check("R5 value 0x10", {24'd0, out_val}, 32'h10);
    prog[2] = enc_r(0, 2, 5, 5'd0, 6'h23);
    run_prog("R6 subtract wraps");
    check("R6 value 0xE0", {24'd0, out_val}, 32'hE0);

    // R8 write to register 0 dropped
    fill_nops();
    prog[0] = enc_i(6'h09, 0, 0, 16'd9);
    prog[1] = enc_r(0, 0, 5, 5'd0, 6'h21);
    run_prog("R8 zero register");
    check("R8 value 0", {24'd0, out_val}, 32'd0);

    // R7 invalid encodings leave register 5 alone
    fill_nops();
    prog[0] = enc_i(6'h09, 0, 5, 16'd3);
    prog[1] = enc_i(6'h08, 0, 5, 16'd9);
    prog[2] = enc_r(5, 5, 5, 5'd0, 6'h20);
    prog[3] = enc_r(5, 5, 5, 5'd1, 6'h21);
    prog[4] = enc_r(5, 5, 5, 5'd2, 6'h23);
    run_prog("R7 invalid words");
    check("R7 value 3", {24'd0, out_val}, 32'd3);

    // R2 registers cleared by the reset between runs
    fill_nops();
    for (int i = 0; i < MAXPC; i++) prog[i] = enc_r(5, 0, 5, 5'd0, 6'h21);
    run_prog("R2 cleared registers");
    check("R2 value 0", {24'd0, out_val}, 32'd0);

    // random programs, mixed valid and invalid words
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < DEPTH; i++) begin
        int sel;
        int a, b, c;
        sel = int'($urandom % 6);
        a   = int'($urandom % 8);
        b   = int'($urandom % 8);
        c   = int'($urandom % 8);
        case (sel)
          0, 1: prog[i] = enc_i(6'h09, a, b, 16'($urandom));
          2:    prog[i] = enc_r(a, b, c, 5'd0, 6'h21);
          3:    prog[i] = enc_r(a, b, c, 5'd0, 6'h23);
          4:    prog[i] = enc_r(a, b, c, 5'($urandom % 2), 6'($urandom));
          default: prog[i] = enc_i(6'($urandom), a, b, 16'($urandom));
        endcase
      end
      run_prog("R5 random program");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R3 actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule